// File: doc/BRIEF.md
# Byte-Lane Register Bridge for a 32-bit Bus

This block sits between a 32-bit Wishbone master and a peripheral that keeps its
control state in an 8-bit register file, for example a serial-port core. Every
bus input is registered before it is used. The block turns a one-hot byte-select
pattern into the two low bits of a byte address. The mapping follows a static
endianness parameter, and big-endian is the default. Toward the register file it
issues a single-byte write or read strobe. It then places the returned byte on
the matching data lane and produces a one-clock acknowledge.

The 5-bit word-aligned address selects one of eight 32-bit words. Words 0 and 1
hold the eight byte registers. Word 2 and word 3 are two read-only 32-bit debug
words, fed from ports. Words 4 to 7 are unmapped. Because of the input sampling
stage, each transfer waits one cycle longer than a bridge without that stage.

Top module: `wb_byte_bridge`

## Requirements
- R1: After reset, `wb_ack_o`, `rf_we_o` and `rf_re_o` are low and `wb_dat_o` is zero.
- R2: When `wb_cyc_i` and `wb_stb_i` are held high, `wb_ack_o` goes high after the third rising edge at which both are high and stays high for exactly one clock.
- R3: While strobe stays high after an acknowledge, no further acknowledge is given. A new transfer starts only after strobe has been sampled low.
- R4: With `BIG_ENDIAN=1`, select bit k (the only active bit) gives byte offset 3-k. Bit 3 gives offset 0 and bit 0 gives offset 3.
- R5: With `BIG_ENDIAN=0`, select bit k gives byte offset k.
- R6: A write to words 0..1 with exactly one select bit set gives one single-cycle `rf_we_o` pulse in the clock before the acknowledge. `rf_addr_o` = {adr[2], offset}, and `rf_wdat_o` is the byte on the lane of the active select bit, i.e. bits [8k+7:8k].
- R7: A read to words 0..1 with exactly one select bit set gives one single-cycle `rf_re_o` pulse in the clock before the acknowledge. `wb_dat_o` carries the addressed register byte on lane k, and the other lanes are zero.
- R8: A register-space access whose select pattern does not have exactly one bit set is acknowledged with no `rf_we_o` or `rf_re_o` pulse, and a read returns zero.
- R9: A read of word 2 returns `dbg_word0_i` and a read of word 3 returns `dbg_word1_i`, as full 32-bit words for any select pattern.
- R10: A write to word 2 or 3 is acknowledged and changes no register-file byte. No `rf_we_o` pulse is issued.
- R11: An access to words 4..7 is acknowledged with no register-file strobe, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | 5 | Byte address; bits [4:2] select the word |
| wb_sel_i | input | 4 | Byte-lane select, bit k = bits [8k+7:8k] |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Transfer acknowledge |
| dbg_word0_i | input | 32 | First debug word from the core |
| dbg_word1_i | input | 32 | Second debug word from the core |
| rf_addr_o | output | 3 | Byte register index |
| rf_wdat_o | output | 8 | Byte written to the register file |
| rf_we_o | output | 1 | Single-cycle register write strobe |
| rf_re_o | output | 1 | Single-cycle register read strobe |
| rf_rdat_i | input | 8 | Byte read from the register index |

## Verification
The bench attaches one bridge of each endianness to a byte-array model. It writes
through one lane and reads back through another. A bridge with the select-to-offset
order reversed would then place bytes at mirrored indices and read back the wrong
value. Multi-bit and two-bit select patterns check that a decoder accepting more
than one lane does not strobe the register file. A debug-word write followed by a
register read catches a decoder that drops the word bits and corrupts byte 0.
Holding strobe high past the acknowledge, and counting cycles to acknowledge, expose
a bridge that re-acknowledges or that bypasses the input sampling stage.

// File: rtl/wbb_pkg.sv
// Package for the byte-lane bridge: control-state and region encodings.
// Assumes nothing beyond being compiled before the bridge modules.
package wbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_ACK   = 2'd2,
        ST_HOLD  = 2'd3
    } wbb_state_e;

    typedef enum logic [1:0] {
        RG_REGS = 2'd0,
        RG_DBG0 = 2'd1,
        RG_DBG1 = 2'd2,
        RG_NONE = 2'd3
    } wbb_region_e;

endpackage

// File: rtl/wbb_in_sampler.sv
// Input sampling stage: registers every bus input before any decode.
// Assumes a synchronous active-low reset; adds one cycle of latency.
module wbb_in_sampler #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int SEL_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] adr_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] dat_o
);

    // Capture the bus inputs each clock; a request needs cycle and strobe together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o <= 1'b0;
            we_o  <= 1'b0;
            adr_o <= '0;
            sel_o <= '0;
            dat_o <= '0;
        end else begin
            req_o <= cyc_i & stb_i;
            we_o  <= we_i;
            adr_o <= adr_i;
            sel_o <= sel_i;
            dat_o <= dat_i;
        end
    end

endmodule

// File: rtl/wbb_lane_decode.sv
// Select decoder: finds the active lane, checks one-hotness and maps the
// lane to a byte offset under a static endianness choice.
// Assumes SEL_W is a power of two.
module wbb_lane_decode #(
    parameter int SEL_W      = 4,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int LANE_W    = $clog2(SEL_W)
) (
    input  logic [SEL_W-1:0]  sel_i,
    output logic              single_o,
    output logic [LANE_W-1:0] lane_o,
    output logic [LANE_W-1:0] offset_o
);

    // Priority encoder over the select bits; lowest set bit wins.
    always_comb begin
        lane_o = '0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (sel_i[i]) lane_o = LANE_W'(i);
        end
    end

    // A register access needs exactly one active select bit.
    always_comb begin
        single_o = ($countones(sel_i) == 1);
    end

    // Lane-to-offset mapping chosen at elaboration by the endianness parameter.
    generate
        if (BIG_ENDIAN) begin : g_big
            assign offset_o = LANE_W'(SEL_W - 1) - lane_o;
        end else begin : g_little
            assign offset_o = lane_o;
        end
    endgenerate

endmodule

// File: rtl/wbb_rdata_steer.sv
// Read-data steering: places one byte on a chosen lane of the bus word and
// drives every other lane to zero. Purely combinational.
module wbb_rdata_steer #(
    parameter int DATA_W  = 32,
    localparam int SEL_W  = DATA_W / 8,
    localparam int LANE_W = $clog2(SEL_W)
) (
    input  logic [7:0]        byte_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [DATA_W-1:0] word_o
);

    // One multiplexer per lane: the byte or zero.
    generate
        for (genvar g = 0; g < SEL_W; g++) begin : g_lane
            assign word_o[g*8 +: 8] = (lane_i == LANE_W'(g)) ? byte_i : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/wbb_ctrl.sv
// Transfer controller: decodes the sampled request into a region, issues the
// single-cycle register strobe, captures read data and drives the acknowledge.
// Assumes sampled inputs; REG_WORDS is a power of two, at least 2.
module wbb_ctrl
    import wbb_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int REG_WORDS = 2,
    localparam int SEL_W    = DATA_W / 8,
    localparam int LANE_W   = $clog2(SEL_W),
    localparam int WORD_AW  = ADDR_W - LANE_W,
    localparam int RWORD_W  = $clog2(REG_WORDS),
    localparam int RF_AW    = RWORD_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              single_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [LANE_W-1:0] offset_i,
    input  logic [DATA_W-1:0] steered_i,
    input  logic [DATA_W-1:0] dbg0_i,
    input  logic [DATA_W-1:0] dbg1_i,
    output logic [LANE_W-1:0] lane_q_o,
    output logic [RF_AW-1:0]  rf_addr_o,
    output logic [7:0]        rf_wdat_o,
    output logic              rf_we_o,
    output logic              rf_re_o,
    output logic [DATA_W-1:0] dat_o,
    output logic              ack_o
);

    wbb_state_e         state_q;
    wbb_region_e        region_d, region_q;
    logic               we_q;
    logic               single_q;
    logic [WORD_AW-1:0] word_idx;

    assign word_idx = adr_i[ADDR_W-1:LANE_W];

    // Region decode of the sampled word index.
    always_comb begin
        if (word_idx < WORD_AW'(REG_WORDS))          region_d = RG_REGS;
        else if (word_idx == WORD_AW'(REG_WORDS))    region_d = RG_DBG0;
        else if (word_idx == WORD_AW'(REG_WORDS + 1)) region_d = RG_DBG1;
        else                                          region_d = RG_NONE;
    end

    // Sequencer: accept, strobe, acknowledge, then wait for strobe release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            region_q  <= RG_NONE;
            we_q      <= 1'b0;
            single_q  <= 1'b0;
            lane_q_o  <= '0;
            rf_addr_o <= '0;
            rf_wdat_o <= '0;
            rf_we_o   <= 1'b0;
            rf_re_o   <= 1'b0;
            dat_o     <= '0;
            ack_o     <= 1'b0;
        end else begin
            rf_we_o <= 1'b0;
            rf_re_o <= 1'b0;
            ack_o   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        state_q   <= ST_ISSUE;
                        region_q  <= region_d;
                        we_q      <= we_i;
                        single_q  <= single_i;
                        lane_q_o  <= lane_i;
                        rf_addr_o <= {word_idx[RWORD_W-1:0], offset_i};
                        rf_wdat_o <= dat_i[lane_i*8 +: 8];
                        rf_we_o   <= we_i & single_i & (region_d == RG_REGS);
                        rf_re_o   <= ~we_i & single_i & (region_d == RG_REGS);
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_ACK;
                    ack_o   <= 1'b1;
                    if (we_q) begin
                        dat_o <= '0;
                    end else begin
                        unique case (region_q)
                            RG_REGS: dat_o <= single_q ? steered_i : '0;
                            RG_DBG0: dat_o <= dbg0_i;
                            RG_DBG1: dat_o <= dbg1_i;
                            default: dat_o <= '0;
                        endcase
                    end
                end
                ST_ACK: begin
                    state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (!req_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wb_byte_bridge.sv
// Top of the byte-lane bridge: 32-bit Wishbone slave in front of an 8-bit
// register file plus two read-only debug words.
// Assumes the register file returns rf_rdat_i combinationally from rf_addr_o.
module wb_byte_bridge #(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 32,
    parameter int REG_WORDS  = 2,
    parameter bit BIG_ENDIAN = 1'b1,
    localparam int SEL_W     = DATA_W / 8,
    localparam int LANE_W    = $clog2(SEL_W),
    localparam int RF_AW     = $clog2(REG_WORDS) + LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [SEL_W-1:0]  wb_sel_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    input  logic [DATA_W-1:0] dbg_word0_i,
    input  logic [DATA_W-1:0] dbg_word1_i,
    output logic [RF_AW-1:0]  rf_addr_o,
    output logic [7:0]        rf_wdat_o,
    output logic              rf_we_o,
    output logic              rf_re_o,
    input  logic [7:0]        rf_rdat_i
);

    logic              s_req, s_we;
    logic [ADDR_W-1:0] s_adr;
    logic [SEL_W-1:0]  s_sel;
    logic [DATA_W-1:0] s_dat;
    logic              single;
    logic [LANE_W-1:0] lane, offset, lane_q;
    logic [DATA_W-1:0] steered;

    wbb_in_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_sampler (
        .clk(clk), .rst_n(rst_n),
        .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .we_i(wb_we_i),
        .adr_i(wb_adr_i), .sel_i(wb_sel_i), .dat_i(wb_dat_i),
        .req_o(s_req), .we_o(s_we), .adr_o(s_adr), .sel_o(s_sel), .dat_o(s_dat)
    );

    wbb_lane_decode #(.SEL_W(SEL_W), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
        .sel_i(s_sel), .single_o(single), .lane_o(lane), .offset_o(offset)
    );

    wbb_rdata_steer #(.DATA_W(DATA_W)) u_steer (
        .byte_i(rf_rdat_i), .lane_i(lane_q), .word_o(steered)
    );

    wbb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_WORDS(REG_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_i(s_req), .we_i(s_we), .adr_i(s_adr), .dat_i(s_dat),
        .single_i(single), .lane_i(lane), .offset_i(offset),
        .steered_i(steered), .dbg0_i(dbg_word0_i), .dbg1_i(dbg_word1_i),
        .lane_q_o(lane_q), .rf_addr_o(rf_addr_o), .rf_wdat_o(rf_wdat_o),
        .rf_we_o(rf_we_o), .rf_re_o(rf_re_o), .dat_o(wb_dat_o), .ack_o(wb_ack_o)
    );

endmodule

// File: rtl/wbb_bridge_chk.sv
// Protocol checker for the byte-lane bridge, bound onto every instance.
// Observes ports only; all properties are disabled during reset.
module wbb_bridge_chk #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int REG_WORDS = 2,
    localparam int SEL_W    = DATA_W / 8,
    localparam int LANE_W   = $clog2(SEL_W),
    localparam int WORD_AW  = ADDR_W - LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_cyc_i,
    input logic              wb_stb_i,
    input logic [ADDR_W-1:0] wb_adr_i,
    input logic [SEL_W-1:0]  wb_sel_i,
    input logic              wb_ack_o,
    input logic              rf_we_o,
    input logic              rf_re_o
);

    // R2: acknowledge lasts a single clock.
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |=> !wb_ack_o);

    // R2: acknowledge only follows a request seen two edges earlier.
    p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack_o |-> $past(wb_cyc_i && wb_stb_i, 2));

    // R6: a write strobe is one clock wide and is followed by acknowledge.
    p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> (!rf_we_o && wb_ack_o));

    // R7: a read strobe is one clock wide and is followed by acknowledge.
    p_re_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re_o |=> (!rf_re_o && wb_ack_o));

    // R6/R7: never both strobes together.
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we_o, rf_re_o}));

    // R8: a strobe requires exactly one select bit in the originating request.
    p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o || rf_re_o) |-> ($countones($past(wb_sel_i, 2)) == 1));

    // R10/R11: a strobe only targets register-space words.
    p_strobe_region_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o || rf_re_o) |->
            ($past(wb_adr_i[ADDR_W-1:LANE_W], 2) < WORD_AW'(REG_WORDS)));

endmodule

bind wb_byte_bridge wbb_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_WORDS(REG_WORDS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i),
    .wb_adr_i(wb_adr_i), .wb_sel_i(wb_sel_i), .wb_ack_o(wb_ack_o),
    .rf_we_o(rf_we_o), .rf_re_o(rf_re_o)
);

// File: tb/wb_byte_bridge_tb_top.sv
// Bench: a big-endian bridge (dut_i) and a little-endian bridge share one bus;
// each drives its own byte-array register model.
module wb_byte_bridge_tb_top;

    localparam time TCLK = 8ns;
    localparam logic [31:0] DBG0 = 32'h1357_2468;
    localparam logic [31:0] DBG1 = 32'h9ABC_DEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [4:0]  adr = '0;
    logic [3:0]  sel = '0;
    logic [31:0] wdat = '0;

    logic [31:0] dat_be, dat_le;
    logic        ack_be, ack_le;
    logic [2:0]  addr_be, addr_le;
    logic [7:0]  wd_be, wd_le;
    logic        we_be, we_le, re_be, re_le;
    logic [7:0]  mem_be [8];
    logic [7:0]  mem_le [8];
    logic [7:0]  rd_be, rd_le;

    int n_chk = 0;
    int n_bad = 0;

    always #(TCLK/2) clk = ~clk;

    assign rd_be = mem_be[addr_be];
    assign rd_le = mem_le[addr_le];

    // Register-file models: write on strobe.
    always @(posedge clk) begin
        if (we_be) mem_be[addr_be] <= wd_be;
        if (we_le) mem_le[addr_le] <= wd_le;
    end

    wb_byte_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(dat_be),
        .wb_ack_o(ack_be), .dbg_word0_i(DBG0), .dbg_word1_i(DBG1),
        .rf_addr_o(addr_be), .rf_wdat_o(wd_be), .rf_we_o(we_be), .rf_re_o(re_be),
        .rf_rdat_i(rd_be)
    );

    wb_byte_bridge #(.BIG_ENDIAN(1'b0)) dut_le_i (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(dat_le),
        .wb_ack_o(ack_le), .dbg_word0_i(DBG0), .dbg_word1_i(DBG1),
        .rf_addr_o(addr_le), .rf_wdat_o(wd_le), .rf_we_o(we_le), .rf_re_o(re_le),
        .rf_rdat_i(rd_le)
    );

    typedef struct packed {
        logic        w;
        logic [4:0]  a;
        logic [3:0]  s;
        logic [31:0] d;
        logic [31:0] x;
    } vec_t;

    // Expected read values are for the big-endian bridge.
    localparam vec_t VEC [17] = '{
        '{1'b1, 5'd0,  4'b1000, 32'hA100_0000, 32'h0},          // R4 lane3 -> byte 0
        '{1'b1, 5'd0,  4'b0001, 32'h0000_00B4, 32'h0},          // R4 lane0 -> byte 3
        '{1'b1, 5'd4,  4'b0100, 32'h00C5_0000, 32'h0},          // R6 byte 5
        '{1'b1, 5'd4,  4'b0010, 32'h0000_D600, 32'h0},          // R6 byte 6
        '{1'b0, 5'd0,  4'b1000, 32'h0, 32'hA100_0000},          // R7
        '{1'b0, 5'd0,  4'b0001, 32'h0, 32'h0000_00B4},          // R7
        '{1'b0, 5'd4,  4'b0100, 32'h0, 32'h00C5_0000},          // R7
        '{1'b0, 5'd4,  4'b0010, 32'h0, 32'h0000_D600},          // R7
        '{1'b0, 5'd0,  4'b0100, 32'h0, 32'h0},                  // R7 untouched byte 1
        '{1'b1, 5'd0,  4'b0011, 32'hFFFF_FFFF, 32'h0},          // R8 two lanes
        '{1'b0, 5'd0,  4'b0001, 32'h0, 32'h0000_00B4},          // R8 byte 3 intact
        '{1'b0, 5'd0,  4'b1100, 32'h0, 32'h0},                  // R8 read zero
        '{1'b0, 5'd8,  4'b1111, 32'h0, DBG0},                   // R9
        '{1'b0, 5'd12, 4'b0001, 32'h0, DBG1},                   // R9
        '{1'b1, 5'd8,  4'b1000, 32'h5500_0000, 32'h0},          // R10
        '{1'b0, 5'd16, 4'b0001, 32'h0, 32'h0},                  // R11
        '{1'b0, 5'd0,  4'b1000, 32'h0, 32'hA100_0000}           // R10 byte 0 intact
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // One bus transfer; returns data, edges to ack, strobe counts (big-endian unit).
    task automatic xfer(input logic w, input logic [4:0] a, input logic [3:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output int n,
                        output int nwe, output int nre, output logic prev,
                        output logic ack_after);
        logic done = 1'b0;
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; sel = s; wdat = d;
        n = 0; nwe = 0; nre = 0; prev = 1'b0; rd = '0;
        while (!done && n < 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (ack_be) begin
                rd = dat_be;
                done = 1'b1;
            end else begin
                nwe += int'(we_be);
                nre += int'(re_be);
                prev = we_be | re_be;
            end
        end
        cyc = 1'b0; stb = 1'b0;
        @(negedge clk);
        ack_after = ack_be;
        nwe += int'(we_be);
        nre += int'(re_be);
        @(negedge clk);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(TCLK * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int n, nwe, nre;
        logic prev, ack2;
        for (int i = 0; i < 8; i++) begin mem_be[i] = 8'h00; mem_le[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ack", {31'b0, ack_be}, 32'h0);
        check("R1 strobes", {30'b0, we_be, re_be}, 32'h0);
        check("R1 data", dat_be, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 17; v++) begin
            logic reg_hit, one;
            reg_hit = (VEC[v].a[4:2] < 3'd2);
            one = ($countones(VEC[v].s) == 1);
            xfer(VEC[v].w, VEC[v].a, VEC[v].s, VEC[v].d, rd, n, nwe, nre, prev, ack2);
            check("R2 edges to ack", n, 3);
            check("R2 ack width", {31'b0, ack2}, 32'h0);
            check("R6 write strobes", nwe, (VEC[v].w && reg_hit && one) ? 1 : 0);
            check("R7 read strobes", nre, (!VEC[v].w && reg_hit && one) ? 1 : 0);
            if (reg_hit && one)
                check("R6/R7 strobe before ack", {31'b0, prev}, 32'h1);
            if (!VEC[v].w)
                check("R7/R8/R9/R11 read data", rd, VEC[v].x);
        end
        check("R10 rf byte 0 after debug write", {24'b0, mem_be[0]}, 32'hA1);

        // R5 vs R4: lane 0 write lands at byte 0 (little) and byte 3 (big).
        xfer(1'b1, 5'd0, 4'b0001, 32'h0000_0077, rd, n, nwe, nre, prev, ack2);
        check("R5 little-endian byte 0", {24'b0, mem_le[0]}, 32'h77);
        check("R4 big-endian byte 3", {24'b0, mem_be[3]}, 32'h77);
        xfer(1'b1, 5'd4, 4'b0100, 32'h0042_0000, rd, n, nwe, nre, prev, ack2);
        check("R5 little-endian byte 6", {24'b0, mem_le[6]}, 32'h42);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 5'd0; sel = 4'b0001;
        repeat (3) @(negedge clk);
        check("R5 little-endian read lane 0", dat_le, 32'h0000_0077);
        check("R2 ack on little-endian unit", {31'b0, ack_le}, 32'h1);

        // R3: strobe held high after ack gives no second ack.
        n = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            n += int'(ack_be) + int'(ack_le);
        end
        check("R3 no re-ack while strobe held", n, 0);
        cyc = 1'b0; stb = 1'b0;
        repeat (2) @(negedge clk);
        xfer(1'b0, 5'd12, 4'b0010, 32'h0, rd, n, nwe, nre, prev, ack2);
        check("R3 new transfer after release", n, 3);
        check("R9 debug word 1 after release", rd, DBG1);

        finish_run();
    end

endmodule